// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch and Interlock

This block sits between a scalar CPU pipeline and an attached vector coprocessor. Each cycle the pipeline may present one coprocessor-class instruction word together with its address. The block sorts the word into one of five outcomes: a branch on the coprocessor busy state, a read of a coprocessor register into a CPU general register, a write of a CPU value into a coprocessor register, issue of an arithmetic op to the coprocessor's upper or lower slot, or a reserved-instruction exception.

Whether an instruction may proceed depends on how the coprocessor is busy. In macro mode only a per-register hazard matters. In micro mode the instruction's interlock bit decides whether a move waits, and reads wait on a different condition from writes. The stall output is combinational. The pipeline keeps the word on `instValid` while `stall` is high. An instruction is accepted in a cycle with `instValid` high and `stall` low. Its result appears as a one-cycle strobe in the following cycle, with the matching data, address or target held beside the strobe.

Top module: `coproc_dispatch`

## Requirements
- R1: A word is decoded only when bits 31:26 equal CLASS_CODE; any other value raises the reserved exception. Field meanings: op = bits 25:21, rt = bits 20:16, register id = bits 15:11, interlock bit = bit 0.
- R2: When op is 0x08 and rt is below 4, the instruction is a branch. The coprocessor counts as busy when macroBusy or microBusy is high. The branch is taken when busy if rt bit 0 is 1, and when not busy if rt bit 0 is 0.
- R3: The branch target is the instruction address plus 4 plus the sign-extended bits 15:0 shifted left by two.
- R4: rt values 2 and 3 are likely branches, and a likely branch that is not taken raises brNullify. A branch with rt 0 or 1 never raises brNullify.
- R5: The move encodings are: op 0x02 with bits 10:1 zero reads a control register, op 0x01 reads a vector register, op 0x06 with bits 10:1 zero writes a control register, and op 0x05 writes a vector register. copAddr is CTRL_BASE + id*REG_STRIDE for control moves and VEC_BASE + id*REG_STRIDE for vector moves.
- R6: A read strobes gprWrEn with gprWrIdx = rt. gprWrData is copRdData sign-extended from 32 to 64 bits.
- R7: A write strobes copWrite with copWrData equal to gprRtData as sampled when the instruction is accepted.
- R8: While macroBusy is high, a move ignores its interlock bit and stalls exactly while hazardHit is high. hazardId always shows bits 15:11.
- R9: While microBusy is high and macroBusy is low, a read with the interlock bit set stalls until microBusy falls. A read with the bit clear does not stall.
- R10: While microBusy is high and macroBusy is low, a write with the interlock bit set stalls while interlockRelease is low. A write with the bit clear does not stall.
- R11: A word with bit 25 set is an arithmetic op. If bits 5:2 are 1111 it goes to the lower slot: issueLower = 0x10000000 | bits 24:0 and issueUpper = 0x000002FF. Otherwise it goes to the upper slot: issueUpper = bits 24:0 zero-extended and issueLower = 0x8000033C. Either kind stalls while microBusy is high and ignores macroBusy.
- R12: A class-matching word that fits none of R2, R5 or R11 raises resvExc. This includes op 0x08 with rt of 4 or more, and op 0x02 or 0x06 with any of bits 10:1 set.
- R13: After reset all result strobes are low. Each accepted instruction gives exactly one result strobe (brValid, gprWrEn, copWrite, issueValid or resvExc), high for one cycle, in the cycle after acceptance. A stalled cycle gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word present |
| instWord | input | 32 | Coprocessor-class instruction |
| instAddr | input | AW | Address of the instruction |
| macroBusy | input | 1 | Coprocessor busy in macro mode |
| microBusy | input | 1 | Coprocessor busy in micro mode |
| hazardHit | input | 1 | Hazard check reports a conflict on hazardId |
| interlockRelease | input | 1 | Micro-mode interlock released for writes |
| hazardId | output | 5 | Register id offered to the hazard check |
| stall | output | 1 | Hold the instruction (combinational) |
| gprRtData | input | 32 | CPU register value for writes |
| copRdData | input | 32 | Coprocessor read data for copAddr |
| brValid | output | 1 | Branch resolved |
| brTaken | output | 1 | Branch taken |
| brNullify | output | 1 | Kill the delay-slot instruction |
| brTarget | output | AW | Branch target address |
| copAddr | output | AW | Coprocessor register address of a move |
| copWrite | output | 1 | Coprocessor register write strobe |
| copWrData | output | 32 | Coprocessor write data |
| gprWrEn | output | 1 | CPU register write strobe |
| gprWrIdx | output | 5 | CPU destination register |
| gprWrData | output | 64 | Sign-extended read data |
| issueValid | output | 1 | Arithmetic op issued |
| issueUpper | output | 32 | Upper-slot word |
| issueLower | output | 32 | Lower-slot word |
| resvExc | output | 1 | Reserved-instruction exception |

## Verification
The bench builds the block with AW = 32, and with CTRL_BASE and VEC_BASE moved to 0x8000 and 0x10000 so that the two address bases are distinct from each other and from the defaults. At this width the full op field, every rt from 0 to 7, four low-bit patterns and both busy states can be swept, which is 2048 instructions covering every decode outcome and both immediate signs. Directed sequences then hold each stall condition for several cycles and release it, covering macro hazards, micro-mode reads and writes with and without the interlock bit, and arithmetic issue.

// File: rtl/cpd_pkg.sv
`timescale 1ns/1ps
package cpd_pkg;
  typedef struct packed {
    logic accept;
    logic brOp;
    logic brTake;
    logic brNull;
    logic rdOp;
    logic wrOp;
    logic vecSel;
    logic upOp;
    logic loOp;
    logic resvOp;
  } ctlStrobes_t;

  localparam logic [4:0] OP_BRANCH = 5'h08;
  localparam logic [4:0] OP_CTL_RD = 5'h02;
  localparam logic [4:0] OP_VEC_RD = 5'h01;
  localparam logic [4:0] OP_CTL_WR = 5'h06;
  localparam logic [4:0] OP_VEC_WR = 5'h05;

  localparam logic [31:0] UPPER_NOP = 32'h0000_02FF;
  localparam logic [31:0] LOWER_NOP = 32'h8000_033C;
  localparam logic [31:0] LOWER_TAG = 32'h1000_0000;
endpackage

// File: rtl/cpd_ctrl.sv
`timescale 1ns/1ps
module cpd_ctrl
  import cpd_pkg::*;
#(
  parameter logic [5:0] CLASS_CODE = 6'h12
) (
  input  logic        instValid,
  input  logic [31:0] instWord,
  input  logic        macroBusy,
  input  logic        microBusy,
  input  logic        hazardHit,
  input  logic        interlockRelease,
  output logic        stall,
  output logic [4:0]  hazardId,
  output ctlStrobes_t strb
);
  logic       classOk, lowZero, ilk;
  logic [4:0] op, rt;
  logic       isBr, isCtlRd, isVecRd, isCtlWr, isVecWr;
  logic       isRd, isWr, isArith, isLo, isUp, isResv;
  logic       busyAny, moveStall, stallC, takeC;

  assign classOk  = (instWord[31:26] == CLASS_CODE);
  assign op       = instWord[25:21];
  assign rt       = instWord[20:16];
  assign lowZero  = (instWord[10:1] == 10'd0);
  assign ilk      = instWord[0];
  assign hazardId = instWord[15:11];

  assign isBr    = classOk && (op == OP_BRANCH) && (rt[4:2] == 3'd0);
  assign isCtlRd = classOk && (op == OP_CTL_RD) && lowZero;
  assign isVecRd = classOk && (op == OP_VEC_RD);
  assign isCtlWr = classOk && (op == OP_CTL_WR) && lowZero;
  assign isVecWr = classOk && (op == OP_VEC_WR);
  assign isRd    = isCtlRd || isVecRd;
  assign isWr    = isCtlWr || isVecWr;
  assign isArith = classOk && instWord[25];
  assign isLo    = isArith && (instWord[5:2] == 4'hF);
  assign isUp    = isArith && !isLo;
  assign isResv  = !(isBr || isRd || isWr || isArith);

  assign busyAny = macroBusy || microBusy;

  // macro mode wins; interlock bit matters only in micro mode
  always_comb begin
    if (macroBusy)             moveStall = hazardHit;
    else if (microBusy && ilk) moveStall = isRd ? 1'b1 : !interlockRelease;
    else                       moveStall = 1'b0;
  end

  always_comb begin
    if (isRd || isWr) stallC = moveStall;
    else if (isArith) stallC = microBusy;
    else              stallC = 1'b0;
  end

  assign stall = instValid && stallC;
  assign takeC = rt[0] ? busyAny : !busyAny;

  always_comb begin
    strb.accept = instValid && !stallC;
    strb.brOp   = isBr;
    strb.brTake = takeC;
    strb.brNull = rt[1] && !takeC;
    strb.rdOp   = isRd;
    strb.wrOp   = isWr;
    strb.vecSel = isVecRd || isVecWr;
    strb.upOp   = isUp;
    strb.loOp   = isLo;
    strb.resvOp = isResv;
  end
endmodule

// File: rtl/cpd_dp.sv
`timescale 1ns/1ps
module cpd_dp
  import cpd_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] CTRL_BASE  = 'h1000,
  parameter logic [AW-1:0] VEC_BASE   = 'h2000,
  parameter int            REG_STRIDE = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strb,
  input  logic [24:0]   instLow,
  input  logic [AW-1:0] instAddr,
  input  logic [31:0]   gprRtData,
  input  logic [31:0]   copRdData,
  output logic          brValid,
  output logic          brTaken,
  output logic          brNullify,
  output logic [AW-1:0] brTarget,
  output logic [AW-1:0] copAddr,
  output logic          copWrite,
  output logic [31:0]   copWrData,
  output logic          gprWrEn,
  output logic [4:0]    gprWrIdx,
  output logic [63:0]   gprWrData,
  output logic          issueValid,
  output logic [31:0]   issueUpper,
  output logic [31:0]   issueLower,
  output logic          resvExc
);
  localparam int SHIFT   = $clog2(REG_STRIDE);
  localparam int IMM_PAD = AW - 18;

  logic [15:0]   imm;
  logic [4:0]    regId;
  logic [AW-1:0] brOffset, targetNext, addrNext;
  logic [31:0]   upWord, loWord;
  logic          acc;

  assign imm        = instLow[15:0];
  assign regId      = instLow[15:11];
  assign brOffset   = {{IMM_PAD{imm[15]}}, imm, 2'b00};
  assign targetNext = instAddr + AW'(4) + brOffset;
  assign addrNext   = (strb.vecSel ? VEC_BASE : CTRL_BASE) + (AW'(regId) << SHIFT);
  assign upWord     = strb.loOp ? UPPER_NOP : {7'd0, instLow};
  assign loWord     = strb.loOp ? (LOWER_TAG | {7'd0, instLow}) : LOWER_NOP;
  assign acc        = strb.accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brValid    <= 1'b0;
      brTaken    <= 1'b0;
      brNullify  <= 1'b0;
      brTarget   <= '0;
      copAddr    <= '0;
      copWrite   <= 1'b0;
      copWrData  <= '0;
      gprWrEn    <= 1'b0;
      gprWrIdx   <= '0;
      issueValid <= 1'b0;
      issueUpper <= '0;
      issueLower <= '0;
      resvExc    <= 1'b0;
    end else begin
      brValid    <= acc && strb.brOp;
      brTaken    <= acc && strb.brOp && strb.brTake;
      brNullify  <= acc && strb.brOp && strb.brNull;
      copWrite   <= acc && strb.wrOp;
      gprWrEn    <= acc && strb.rdOp;
      issueValid <= acc && (strb.upOp || strb.loOp);
      resvExc    <= acc && strb.resvOp;
      if (acc) begin
        brTarget   <= targetNext;
        copAddr    <= addrNext;
        copWrData  <= gprRtData;
        gprWrIdx   <= instLow[20:16];
        issueUpper <= upWord;
        issueLower <= loWord;
      end
    end
  end

  assign gprWrData = {{32{copRdData[31]}}, copRdData};
endmodule

// File: rtl/coproc_dispatch.sv
`timescale 1ns/1ps
module coproc_dispatch
  import cpd_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] CTRL_BASE  = 'h1000,
  parameter logic [AW-1:0] VEC_BASE   = 'h2000,
  parameter int            REG_STRIDE = 16,
  parameter logic [5:0]    CLASS_CODE = 6'h12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic [31:0]   instWord,
  input  logic [AW-1:0] instAddr,
  input  logic          macroBusy,
  input  logic          microBusy,
  input  logic          hazardHit,
  input  logic          interlockRelease,
  output logic [4:0]    hazardId,
  output logic          stall,
  input  logic [31:0]   gprRtData,
  input  logic [31:0]   copRdData,
  output logic          brValid,
  output logic          brTaken,
  output logic          brNullify,
  output logic [AW-1:0] brTarget,
  output logic [AW-1:0] copAddr,
  output logic          copWrite,
  output logic [31:0]   copWrData,
  output logic          gprWrEn,
  output logic [4:0]    gprWrIdx,
  output logic [63:0]   gprWrData,
  output logic          issueValid,
  output logic [31:0]   issueUpper,
  output logic [31:0]   issueLower,
  output logic          resvExc
);
  ctlStrobes_t strb;

  cpd_ctrl #(.CLASS_CODE(CLASS_CODE)) uCtrl (
    .instValid(instValid), .instWord(instWord),
    .macroBusy(macroBusy), .microBusy(microBusy),
    .hazardHit(hazardHit), .interlockRelease(interlockRelease),
    .stall(stall), .hazardId(hazardId), .strb(strb)
  );

  cpd_dp #(.AW(AW), .CTRL_BASE(CTRL_BASE), .VEC_BASE(VEC_BASE), .REG_STRIDE(REG_STRIDE)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .instLow(instWord[24:0]),
    .instAddr(instAddr), .gprRtData(gprRtData), .copRdData(copRdData),
    .brValid(brValid), .brTaken(brTaken), .brNullify(brNullify), .brTarget(brTarget),
    .copAddr(copAddr), .copWrite(copWrite), .copWrData(copWrData),
    .gprWrEn(gprWrEn), .gprWrIdx(gprWrIdx), .gprWrData(gprWrData),
    .issueValid(issueValid), .issueUpper(issueUpper), .issueLower(issueLower),
    .resvExc(resvExc)
  );
endmodule

// File: rtl/cpd_checker.sv
`timescale 1ns/1ps
module cpd_checker #(
  parameter logic [5:0] CLASS_CODE = 6'h12
) (
  input logic        clk,
  input logic        rstN,
  input logic        instValid,
  input logic [10:0] opField,   // word bits 31:21
  input logic [10:0] lowField,  // word bits 10:0
  input logic        macroBusy,
  input logic        microBusy,
  input logic        hazardHit,
  input logic        stall,
  input logic        brValid,
  input logic        brTaken,
  input logic        brNullify,
  input logic        copWrite,
  input logic        gprWrEn,
  input logic        issueValid,
  input logic        resvExc
);
  logic       cls, midZero, isRead, isMove, isArith;
  logic [4:0] op;
  logic [4:0] results;

  assign cls     = (opField[10:5] == CLASS_CODE);
  assign op      = opField[4:0];
  assign midZero = (lowField[10:1] == 10'd0);
  assign isRead  = cls && ((op == 5'h01) || (op == 5'h02 && midZero));
  assign isMove  = isRead || (cls && ((op == 5'h05) || (op == 5'h06 && midZero)));
  assign isArith = cls && op[4];
  assign results = {brValid, gprWrEn, copWrite, issueValid, resvExc};

  a_r13_one_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(results));
  a_r13_accept_result: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !stall) |=> ($countones(results) == 1));
  a_r13_stall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && stall) |=> (results == 5'd0));
  a_r4_nullify_untaken: assert property (@(posedge clk) disable iff (!rstN)
    brNullify |-> (brValid && !brTaken));
  a_r8_hazard_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && macroBusy && hazardHit && isMove) |-> stall);
  a_r8_no_hazard_go: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && macroBusy && !hazardHit && isMove) |-> !stall);
  a_r9_read_waits: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !macroBusy && microBusy && isRead && lowField[0]) |-> stall);
  a_r11_arith_waits: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && isArith && microBusy) |-> stall);
endmodule

bind coproc_dispatch cpd_checker #(.CLASS_CODE(CLASS_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .instValid(instValid),
  .opField(instWord[31:21]), .lowField(instWord[10:0]),
  .macroBusy(macroBusy), .microBusy(microBusy), .hazardHit(hazardHit),
  .stall(stall), .brValid(brValid), .brTaken(brTaken), .brNullify(brNullify),
  .copWrite(copWrite), .gprWrEn(gprWrEn), .issueValid(issueValid), .resvExc(resvExc)
);

// File: tb/sim_coproc_dispatch.sv
`timescale 1ns/1ps
module sim_coproc_dispatch;
  localparam int          AW = 32;
  localparam logic [31:0] CB = 32'h0000_8000;
  localparam logic [31:0] VB = 32'h0001_0000;
  localparam logic [5:0]  CC = 6'h12;

  logic clk = 1'b0, rstN = 1'b0;
  logic instValid = 1'b0, macroBusy = 1'b0, microBusy = 1'b0;
  logic hazardHit = 1'b0, interlockRelease = 1'b0;
  logic [31:0] instWord = '0, instAddr = '0, gprRtData = '0, copRdData = '0;
  logic [4:0]  hazardId, gprWrIdx;
  logic        stall, brValid, brTaken, brNullify, copWrite, gprWrEn, issueValid, resvExc;
  logic [31:0] brTarget, copAddr, copWrData, issueUpper, issueLower;
  logic [63:0] gprWrData;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  coproc_dispatch #(.AW(AW), .CTRL_BASE(CB), .VEC_BASE(VB), .REG_STRIDE(16), .CLASS_CODE(CC)) u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord), .instAddr(instAddr),
    .macroBusy(macroBusy), .microBusy(microBusy), .hazardHit(hazardHit),
    .interlockRelease(interlockRelease), .hazardId(hazardId), .stall(stall),
    .gprRtData(gprRtData), .copRdData(copRdData),
    .brValid(brValid), .brTaken(brTaken), .brNullify(brNullify), .brTarget(brTarget),
    .copAddr(copAddr), .copWrite(copWrite), .copWrData(copWrData),
    .gprWrEn(gprWrEn), .gprWrIdx(gprWrIdx), .gprWrData(gprWrData),
    .issueValid(issueValid), .issueUpper(issueUpper), .issueLower(issueLower), .resvExc(resvExc)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] resVec();
    return {brValid, gprWrEn, copWrite, issueValid, resvExc};
  endfunction

  // results of an instruction accepted in the previous cycle
  task automatic checkResult(input logic [31:0] w, input logic [31:0] a, input bit busy);
    logic [4:0]  op, rt, id;
    logic        cls, lz, vec, taken;
    logic [4:0]  expVec;
    logic [31:0] expAddr, expTgt;
    op = w[25:21]; rt = w[20:16]; id = w[15:11];
    cls = (w[31:26] == CC); lz = (w[10:1] == 10'd0);
    expAddr = 32'(id) * 16;
    expTgt  = a + 32'd4 + ({{16{w[15]}}, w[15:0]} << 2);
    if (cls && w[25]) begin
      expVec = 5'b00010;
      if (w[5:2] == 4'hF) begin
        chk(issueUpper == 32'h0000_02FF, "R11 lower-slot upper NOP", 64'(issueUpper), 64'h2FF);
        chk(issueLower == (32'h1000_0000 | {7'd0, w[24:0]}), "R11 lower-slot word", 64'(issueLower),
            64'(32'h1000_0000 | {7'd0, w[24:0]}));
      end else begin
        chk(issueUpper == {7'd0, w[24:0]}, "R11 upper-slot word", 64'(issueUpper), 64'({7'd0, w[24:0]}));
        chk(issueLower == 32'h8000_033C, "R11 upper-slot lower NOP", 64'(issueLower), 64'h8000033C);
      end
    end else if (cls && op == 5'h08 && rt < 5'd4) begin
      expVec = 5'b10000;
      taken  = rt[0] ? busy : !busy;
      chk(brTaken == taken, "R2 branch taken", 64'(brTaken), 64'(taken));
      chk(brNullify == (rt[1] && !taken), "R4 nullify", 64'(brNullify), 64'(rt[1] && !taken));
      chk(brTarget == expTgt, "R3 branch target", 64'(brTarget), 64'(expTgt));
    end else if (cls && ((op == 5'h02 && lz) || op == 5'h01)) begin
      expVec = 5'b01000;
      vec = (op == 5'h01);
      chk(copAddr == (vec ? VB : CB) + expAddr, "R5 read address", 64'(copAddr), 64'((vec ? VB : CB) + expAddr));
      chk(gprWrIdx == rt, "R6 read destination", 64'(gprWrIdx), 64'(rt));
      chk(gprWrData == {{32{copRdData[31]}}, copRdData}, "R6 sign extension", gprWrData,
          {{32{copRdData[31]}}, copRdData});
    end else if (cls && ((op == 5'h06 && lz) || op == 5'h05)) begin
      expVec = 5'b00100;
      vec = (op == 5'h05);
      chk(copAddr == (vec ? VB : CB) + expAddr, "R5 write address", 64'(copAddr), 64'((vec ? VB : CB) + expAddr));
      chk(copWrData == (w ^ 32'hA5A5_5A5A), "R7 write data", 64'(copWrData), 64'(w ^ 32'hA5A5_5A5A));
    end else begin
      expVec = 5'b00001;
    end
    chk(resVec() == expVec, (expVec == 5'b00001) ? "R12 reserved / R1 class" : "R13 result strobe",
        64'(resVec()), 64'(expVec));
  endtask

  task automatic present(input logic [31:0] w, input logic [31:0] a);
    instWord = w; instAddr = a; instValid = 1'b1;
    gprRtData = w ^ 32'hA5A5_5A5A;
    copRdData = {w[15:0], w[31:16]};
  endtask

  task automatic runSweep();
    logic [10:0] lows [4];
    logic [31:0] w, a;
    lows[0] = 11'h000; lows[1] = 11'h001; lows[2] = 11'h03C; lows[3] = 11'h402;
    for (int op = 0; op < 32; op++)
      for (int pat = 0; pat < 4; pat++)
        for (int rt = 0; rt < 8; rt++)
          for (int b = 0; b < 2; b++) begin
            w = {CC, 5'(op), 5'(rt), 5'(op + rt + pat), lows[pat]};
            a = {4'h1, 5'(op), 3'(rt), 2'(pat), 1'(b), 17'h0};
            @(negedge clk);
            present(w, a);
            macroBusy = 1'(b); microBusy = 1'b0; hazardHit = 1'b0;
            #1 chk(stall == 1'b0, "R8 macro busy without hazard", 64'(stall), 0);
            @(negedge clk);
            instValid = 1'b0;
            checkResult(w, a, 1'(b));
          end
  endtask

  task automatic expectQuiet(input string tag);
    chk(resVec() == 5'd0, tag, 64'(resVec()), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectQuiet("R13 reset state");
    chk(stall == 1'b0, "R13 no stall when idle", 64'(stall), 0);

    runSweep();

    // R8: macro hazard, interlock bit ignored even with micro busy
    @(negedge clk);
    w = {CC, 5'h01, 5'd3, 5'd5, 11'h001};
    present(w, 32'h100);
    macroBusy = 1'b1; microBusy = 1'b1; hazardHit = 1'b1;
    #1 chk(stall == 1'b1, "R8 hazard stalls", 64'(stall), 1);
    chk(hazardId == 5'd5, "R8 hazard id", 64'(hazardId), 5);
    @(negedge clk);
    expectQuiet("R13 stalled cycle gives no result");
    chk(stall == 1'b1, "R8 stall held", 64'(stall), 1);
    hazardHit = 1'b0;
    #1 chk(stall == 1'b0, "R8 interlock bit ignored in macro mode", 64'(stall), 0);
    @(negedge clk);
    instValid = 1'b0; macroBusy = 1'b0; microBusy = 1'b0;
    chk(gprWrEn == 1'b1, "R6 read after hazard", 64'(gprWrEn), 1);
    chk(copAddr == VB + 32'd80, "R5 vector address id 5", 64'(copAddr), 64'(VB + 32'd80));
    @(negedge clk);
    expectQuiet("R13 strobe lasts one cycle");

    // R9: micro-mode read
    w = {CC, 5'h02, 5'd7, 5'd2, 11'h001};
    present(w, 32'h200);
    microBusy = 1'b1;
    #1 chk(stall == 1'b1, "R9 interlocked read stalls", 64'(stall), 1);
    @(negedge clk);
    interlockRelease = 1'b1;
    #1 chk(stall == 1'b1, "R9 read ignores release", 64'(stall), 1);
    instWord = {CC, 5'h02, 5'd7, 5'd2, 11'h000};
    #1 chk(stall == 1'b0, "R9 read without interlock bit", 64'(stall), 0);
    instWord = w; interlockRelease = 1'b0;
    @(negedge clk);
    microBusy = 1'b0;
    #1 chk(stall == 1'b0, "R9 read released", 64'(stall), 0);
    @(negedge clk);
    instValid = 1'b0;
    chk(gprWrEn == 1'b1 && gprWrIdx == 5'd7, "R6 control read strobe", 64'({gprWrEn, gprWrIdx}), 64'h27);

    // R10: micro-mode write
    @(negedge clk);
    w = {CC, 5'h06, 5'd1, 5'd9, 11'h001};
    present(w, 32'h300);
    microBusy = 1'b1; interlockRelease = 1'b0;
    #1 chk(stall == 1'b1, "R10 interlocked write stalls", 64'(stall), 1);
    @(negedge clk);
    expectQuiet("R13 stalled write gives no result");
    interlockRelease = 1'b1;
    #1 chk(stall == 1'b0, "R10 release lets write go", 64'(stall), 0);
    @(negedge clk);
    instValid = 1'b0; interlockRelease = 1'b0;
    chk(copWrite == 1'b1, "R10 write strobe", 64'(copWrite), 1);
    chk(copAddr == CB + 32'd144, "R5 control address id 9", 64'(copAddr), 64'(CB + 32'd144));
    @(negedge clk);
    present({CC, 5'h05, 5'd1, 5'd9, 11'h000}, 32'h304);
    #1 chk(stall == 1'b0, "R10 write without interlock bit", 64'(stall), 0);
    @(negedge clk);
    instValid = 1'b0; microBusy = 1'b0;
    chk(copWrite == 1'b1, "R7 vector write strobe", 64'(copWrite), 1);

    // R11: arithmetic issue waits for micro mode only
    @(negedge clk);
    w = {CC, 5'h10, 5'd3, 5'd4, 11'h123};
    present(w, 32'h400);
    microBusy = 1'b1;
    #1 chk(stall == 1'b1, "R11 issue waits on micro", 64'(stall), 1);
    @(negedge clk);
    microBusy = 1'b0; macroBusy = 1'b1;
    #1 chk(stall == 1'b0, "R11 macro busy does not stall issue", 64'(stall), 0);
    @(negedge clk);
    instValid = 1'b0; macroBusy = 1'b0;
    chk(issueValid == 1'b1 && issueUpper == {7'd0, w[24:0]}, "R11 upper issue", 64'(issueUpper),
        64'({7'd0, w[24:0]}));

    // R1: wrong class code
    @(negedge clk);
    present({6'h11, 5'h01, 5'd0, 5'd0, 11'h0}, 32'h500);
    @(negedge clk);
    instValid = 1'b0;
    chk(resvExc == 1'b1, "R1 class mismatch reserved", 64'(resvExc), 1);

    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule